// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with FIFO Replacement

This block is a fully associative address translation cache. It holds twenty page mappings. Each mapping ties a virtual page number and the identifier of its owning process to a physical frame number. A lookup presents a process identifier and a full virtual address. The block answers in the same cycle with a hit flag and a physical address. That address is the stored frame number with the untranslated 9-bit page offset appended, because pages are 512 bytes.

After a miss, the page walker outside the block resolves the frame and writes it through the insert port. The access is then retried. The block keeps the tag of every process, so a context switch does not empty it. When a process exits, a kill request drops only the private entries of that process in one clock. An entry inserted as shared is global: it matches any process on the page number alone, and a kill never drops it.

Top module: `ptlb_tlb`

## Requirements
- R1: After reset, every entry is invalid, the replacement pointer is 0, and every lookup reports a miss.
- R2: A private entry hits only when both the process identifier and the virtual page number (lk_vaddr[31:9]) match. On a hit, lk_paddr equals {frame, lk_vaddr[8:0]}.
- R3: An entry inserted with ins_shared=1 hits for any process identifier whose virtual page number matches.
- R4: An insert whose pair (process identifier, page number) already hits an entry rewrites that entry in place, with its frame and shared flag. No other entry is consumed and the pointer does not move.
- R5: A new insert takes the lowest-index invalid entry when one exists, and the replacement pointer stays unchanged.
- R6: When all entries are valid, a new insert overwrites the entry at the pointer. The pointer then steps by one and wraps from 19 to 0, so the oldest fill is evicted first.
- R7: A kill drops every private entry tagged with kill_pid and leaves entries of other processes intact.
- R8: Shared entries survive a kill of any process identifier.
- R9: A lookup in the same cycle as a kill reports a miss for private entries of the killed identifier.
- R10: An insert in the same cycle as a kill with the same process identifier is discarded.
- R11: An insert becomes visible to lookups from the next cycle. A lookup in the insert cycle sees the old contents.
- R12: lk_hit is never 1 while lk_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pid | input | 8 | Process identifier of the lookup |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_paddr | output | 25 | Translated physical address, valid with lk_hit |
| ins_valid | input | 1 | Write a mapping |
| ins_pid | input | 8 | Owner of the new mapping |
| ins_vpn | input | 23 | Virtual page number of the new mapping |
| ins_pfn | input | 16 | Physical frame number of the new mapping |
| ins_shared | input | 1 | Mark the mapping as shared among processes |
| kill_valid | input | 1 | Drop the private entries of a process |
| kill_pid | input | 8 | Process identifier being dropped |

## Verification
The assertions assume that the caller never inserts a shared mapping for a page number that another live entry also claims under a different process. Under that rule at most one entry can match a query, and the one-hot check on the match vector relies on it. The random stimulus keeps to this rule by reserving page numbers 24 to 31 for shared inserts and using 0 to 23 for private ones. Process identifiers are drawn from a small set, so kills, in-place updates and cross-process misses occur often.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    typedef enum logic [1:0] {
        INS_NONE   = 2'd0,
        INS_UPDATE = 2'd1,
        INS_FILL   = 2'd2,
        INS_EVICT  = 2'd3
    } ins_act_e;

endpackage

// File: rtl/ptlb_match.sv
module ptlb_match #(
    parameter int N     = 20,
    parameter int PID_W = 8,
    parameter int VPN_W = 23
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0]             shared,
    input  logic [N-1:0][PID_W-1:0]  pid,
    input  logic [N-1:0][VPN_W-1:0]  vpn,
    input  logic [PID_W-1:0]         q_pid,
    input  logic [VPN_W-1:0]         q_vpn,
    output logic [N-1:0]             hits
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hits[i] = valid[i] && (vpn[i] == q_vpn) &&
                         (shared[i] || (pid[i] == q_pid));
    end

endmodule

// File: rtl/ptlb_prio_enc.sv
module ptlb_prio_enc #(
    parameter int N     = 20,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ptlb_tlb.sv
module ptlb_tlb #(
    parameter int N      = 20,
    parameter int PID_W  = 8,
    parameter int VA_W   = 32,
    parameter int OFF_W  = 9,
    parameter int PFN_W  = 16,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PFN_W + OFF_W,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              ins_valid,
    input  logic [PID_W-1:0]  ins_pid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [PFN_W-1:0]  ins_pfn,
    input  logic              ins_shared,
    input  logic              kill_valid,
    input  logic [PID_W-1:0]  kill_pid
);
    import ptlb_pkg::*;

    typedef struct packed {
        logic [N-1:0]            valid;
        logic [N-1:0]            shared;
        logic [N-1:0][PID_W-1:0] pid;
        logic [N-1:0][VPN_W-1:0] vpn;
        logic [N-1:0][PFN_W-1:0] pfn;
        logic [IDX_W-1:0]        ptr;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]     valid_q;
    logic [IDX_W-1:0] ptr_q;
    logic [N-1:0]     kill_mask;
    logic [N-1:0]     lk_raw;
    logic [N-1:0]     lk_hits;
    logic             lk_shared_hit;
    logic [PFN_W-1:0] lk_frame;
    logic [N-1:0]     ins_hits;
    logic [IDX_W-1:0] ins_hit_idx;
    logic             ins_hit_any;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic             ins_ok;
    logic [IDX_W-1:0] wr_idx;
    ins_act_e         ins_act;

    assign valid_q = st_q.valid;
    assign ptr_q   = st_q.ptr;

    for (genvar i = 0; i < N; i++) begin : g_kill
        assign kill_mask[i] = kill_valid && !st_q.shared[i] &&
                              (st_q.pid[i] == kill_pid);
    end

    ptlb_match #(.N(N), .PID_W(PID_W), .VPN_W(VPN_W)) u_lk_match (
        .valid  (st_q.valid),
        .shared (st_q.shared),
        .pid    (st_q.pid),
        .vpn    (st_q.vpn),
        .q_pid  (lk_pid),
        .q_vpn  (lk_vaddr[VA_W-1:OFF_W]),
        .hits   (lk_raw)
    );

    ptlb_match #(.N(N), .PID_W(PID_W), .VPN_W(VPN_W)) u_ins_match (
        .valid  (st_q.valid),
        .shared (st_q.shared),
        .pid    (st_q.pid),
        .vpn    (st_q.vpn),
        .q_pid  (ins_pid),
        .q_vpn  (ins_vpn),
        .hits   (ins_hits)
    );

    ptlb_prio_enc #(.N(N), .IDX_W(IDX_W)) u_hit_enc (
        .vec (ins_hits),
        .idx (ins_hit_idx),
        .any (ins_hit_any)
    );

    ptlb_prio_enc #(.N(N), .IDX_W(IDX_W)) u_free_enc (
        .vec (~st_q.valid),
        .idx (free_idx),
        .any (free_any)
    );

    // lookup result path
    always_comb begin
        lk_hits       = lk_valid ? (lk_raw & ~kill_mask) : '0;
        lk_shared_hit = |(lk_hits & st_q.shared);
        lk_frame      = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_hits[i]) begin
                lk_frame = lk_frame | st_q.pfn[i];
            end
        end
        lk_hit   = |lk_hits;
        lk_paddr = {lk_frame, lk_vaddr[OFF_W-1:0]};
    end

    // next-state computation
    always_comb begin
        st_d   = st_q;
        ins_ok = ins_valid && !(kill_valid && (kill_pid == ins_pid));
        wr_idx = st_q.ptr;

        if (!ins_ok) begin
            ins_act = INS_NONE;
        end else if (ins_hit_any) begin
            ins_act = INS_UPDATE;
            wr_idx  = ins_hit_idx;
        end else if (free_any) begin
            ins_act = INS_FILL;
            wr_idx  = free_idx;
        end else begin
            ins_act = INS_EVICT;
        end

        st_d.valid = st_q.valid & ~kill_mask;

        if (ins_act != INS_NONE) begin
            st_d.valid[wr_idx]  = 1'b1;
            st_d.shared[wr_idx] = ins_shared;
            st_d.pid[wr_idx]    = ins_pid;
            st_d.vpn[wr_idx]    = ins_vpn;
            st_d.pfn[wr_idx]    = ins_pfn;
        end

        if (ins_act == INS_EVICT) begin
            st_d.ptr = (st_q.ptr == IDX_W'(N - 1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
    parameter int N     = 20,
    parameter int PID_W = 8,
    parameter int VA_W  = 32,
    parameter int OFF_W = 9,
    parameter int PA_W  = 25,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [PID_W-1:0] lk_pid,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             ins_valid,
    input logic             kill_valid,
    input logic [PID_W-1:0] kill_pid,
    input logic [N-1:0]     lk_hits,
    input logic             lk_shared_hit,
    input logic [N-1:0]     valid_q,
    input logic [IDX_W-1:0] ptr_q
);

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hits));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R9
    kill_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_valid && lk_valid && (lk_pid == kill_pid) && !lk_shared_hit)
        |-> !lk_hit);

    // R12
    idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < IDX_W'(N));

    // R5
    fill_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !kill_valid)
        |=> ($countones(valid_q) >= $past($countones(valid_q))));

    // R11
    quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !kill_valid) |=> ($stable(valid_q) && $stable(ptr_q)));

endmodule

bind ptlb_tlb ptlb_chk #(
    .N(N), .PID_W(PID_W), .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .IDX_W(IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_pid        (lk_pid),
    .lk_vaddr      (lk_vaddr),
    .lk_hit        (lk_hit),
    .lk_paddr      (lk_paddr),
    .ins_valid     (ins_valid),
    .kill_valid    (kill_valid),
    .kill_pid      (kill_pid),
    .lk_hits       (lk_hits),
    .lk_shared_hit (lk_shared_hit),
    .valid_q       (valid_q),
    .ptr_q         (ptr_q)
);

// File: tb/tb_ptlb_tlb.sv
module tb_ptlb_tlb;
    localparam int N = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [7:0]  lk_pid = '0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [24:0] lk_paddr;
    logic        ins_valid = 1'b0;
    logic [7:0]  ins_pid = '0;
    logic [22:0] ins_vpn = '0;
    logic [15:0] ins_pfn = '0;
    logic        ins_shared = 1'b0;
    logic        kill_valid = 1'b0;
    logic [7:0]  kill_pid = '0;

    int checks = 0;
    int fails  = 0;

    logic        m_valid [N];
    logic        m_sh    [N];
    logic [7:0]  m_pid   [N];
    logic [22:0] m_vpn   [N];
    logic [15:0] m_pfn   [N];
    int          m_ptr;

    always #2 clk = ~clk;

    ptlb_tlb dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .ins_valid(ins_valid), .ins_pid(ins_pid), .ins_vpn(ins_vpn),
        .ins_pfn(ins_pfn), .ins_shared(ins_shared),
        .kill_valid(kill_valid), .kill_pid(kill_pid)
    );

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_sh[i] = 1'b0;
            m_pid[i] = '0; m_vpn[i] = '0; m_pfn[i] = '0;
        end
        m_ptr = 0;
    endfunction

    function automatic int model_find(logic [7:0] p, logic [22:0] v);
        for (int i = 0; i < N; i++) begin
            if (m_valid[i] && m_vpn[i] == v && (m_sh[i] || m_pid[i] == p)) return i;
        end
        return -1;
    endfunction

    function automatic void summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endfunction

    // one cycle: drive, check lookup, update model, advance
    task automatic step(input logic lv, input logic [7:0] lp, input logic [31:0] la,
                        input logic iv, input logic [7:0] ip, input logic [22:0] ivpn,
                        input logic [15:0] ipfn, input logic ish,
                        input logic kv, input logic [7:0] kp,
                        input int exp_hit, input string tag);
        int j, h, fr;
        logic        e_hit;
        logic [24:0] e_pa;
        logic        ins_ok;
        @(negedge clk);
        lk_valid = lv; lk_pid = lp; lk_vaddr = la;
        ins_valid = iv; ins_pid = ip; ins_vpn = ivpn; ins_pfn = ipfn; ins_shared = ish;
        kill_valid = kv; kill_pid = kp;
        #1;
        j = model_find(lp, la[31:9]);
        e_hit = lv && (j >= 0) && !(kv && !m_sh[j] && m_pid[j] == kp);
        e_pa  = e_hit ? {m_pfn[j], la[8:0]} : {16'h0, la[8:0]};
        if (lv) begin
            checks++;
            if (lk_hit !== e_hit || (e_hit && lk_paddr !== e_pa)) begin
                fails++;
                $display("FAIL %s: hit=%0b paddr=%h expected hit=%0b paddr=%h",
                         tag, lk_hit, lk_paddr, e_hit, e_pa);
            end
            if (exp_hit >= 0) begin
                checks++;
                if (lk_hit !== exp_hit[0]) begin
                    fails++;
                    $display("FAIL %s: hit=%0b expected %0d", tag, lk_hit, exp_hit);
                end
            end
        end else begin
            checks++;
            if (lk_hit !== 1'b0) begin
                fails++;
                $display("FAIL R12: hit=%0b expected 0", lk_hit);
            end
        end
        ins_ok = iv && !(kv && kp == ip);
        h = model_find(ip, ivpn);
        fr = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) fr = i;
        if (kv) begin
            for (int i = 0; i < N; i++)
                if (m_valid[i] && !m_sh[i] && m_pid[i] == kp) m_valid[i] = 1'b0;
        end
        if (ins_ok) begin
            int w;
            if (h >= 0) w = h;
            else if (fr >= 0) w = fr;
            else begin
                w = m_ptr;
                m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
            end
            m_valid[w] = 1'b1; m_sh[w] = ish; m_pid[w] = ip;
            m_vpn[w] = ivpn; m_pfn[w] = ipfn;
        end
        @(posedge clk);
    endtask

    task automatic look(input logic [7:0] p, input logic [22:0] v, input int eh,
                        input string tag);
        step(1'b1, p, {v, 9'h0A5}, 1'b0, 8'h0, 23'h0, 16'h0, 1'b0, 1'b0, 8'h0, eh, tag);
    endtask

    task automatic put(input logic [7:0] p, input logic [22:0] v, input logic [15:0] f,
                       input logic sh);
        step(1'b0, 8'h0, 32'h0, 1'b1, p, v, f, sh, 1'b0, 8'h0, -1, "R12");
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed;
        model_reset();
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(8'd1, 23'd5, 0, "R1");
        look(8'd0, 23'd0, 0, "R1");

        // R11: same-cycle insert not seen, seen next cycle
        step(1'b1, 8'd1, {23'd5, 9'h011}, 1'b1, 8'd1, 23'd5, 16'h0100, 1'b0,
             1'b0, 8'h0, 0, "R11");
        look(8'd1, 23'd5, 1, "R11");
        // R2: other PID misses, paddr composed
        look(8'd2, 23'd5, 0, "R2");

        // R5: fill remaining slots, nothing lost
        for (int i = 1; i < N; i++) put(8'd1, 23'(100 + i), 16'(16'h0200 + i), 1'b0);
        look(8'd1, 23'd5, 1, "R5");
        look(8'd1, 23'd119, 1, "R5");

        // R4: rewrite in place, nothing evicted
        put(8'd1, 23'd5, 16'h0ABC, 1'b0);
        look(8'd1, 23'd5, 1, "R4");
        for (int i = 1; i < N; i++) look(8'd1, 23'(100 + i), 1, "R4");

        // R6: full, FIFO eviction from slot 0 then 1
        put(8'd2, 23'd7, 16'h0300, 1'b0);
        look(8'd1, 23'd5, 0, "R6");
        look(8'd1, 23'd101, 1, "R6");
        put(8'd2, 23'd8, 16'h0301, 1'b0);
        look(8'd1, 23'd101, 0, "R6");
        look(8'd2, 23'd7, 1, "R6");

        // R9: kill with same-cycle lookup
        step(1'b1, 8'd1, {23'd102, 9'h1FF}, 1'b0, 8'h0, 23'h0, 16'h0, 1'b0,
             1'b1, 8'd1, 0, "R9");
        // R7: other process intact, killed gone
        look(8'd2, 23'd7, 1, "R7");
        look(8'd1, 23'd103, 0, "R7");

        // R3 / R8: shared mapping
        put(8'd3, 23'd50, 16'h0777, 1'b1);
        look(8'd4, 23'd50, 1, "R3");
        step(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, 23'h0, 16'h0, 1'b0, 1'b1, 8'd3, -1, "R12");
        look(8'd3, 23'd50, 1, "R8");
        look(8'd9, 23'd50, 1, "R8");

        // R10: insert discarded when killed same cycle
        step(1'b0, 8'h0, 32'h0, 1'b1, 8'd5, 23'd60, 16'h0555, 1'b0, 1'b1, 8'd5, -1, "R12");
        look(8'd5, 23'd60, 0, "R10");

        // R12: idle lookup port never hits
        step(1'b0, 8'd2, {23'd7, 9'h0}, 1'b0, 8'h0, 23'h0, 16'h0, 1'b0, 1'b0, 8'h0, -1, "R12");

        // random mix: private VPNs 0..23, shared VPNs 24..31
        for (int n = 0; n < 4000; n++) begin
            logic        sh;
            logic [22:0] iv;
            sh = ($urandom % 10) == 0;
            iv = sh ? 23'(24 + $urandom % 8) : 23'($urandom % 24);
            step(($urandom % 5) != 0, 8'($urandom % 4), {23'($urandom % 32), 9'($urandom)},
                 ($urandom % 10) < 3, 8'($urandom % 4), iv, 16'($urandom), sh,
                 ($urandom % 20) == 0, 8'($urandom % 4), -1, "R2/R3/R6/R7");
        end

        summary();
        $finish;
    end

endmodule